// File: doc/BRIEF.md
# Masked packed float subtract unit

This block subtracts two vectors of single-precision floating-point numbers lane by lane, each result being the first source minus the second. A vector holds up to sixteen 32-bit lanes (512 bits). Under lane-predicate control it then merges the results into the prior destination value. Three encoding forms are accepted:

- The legacy form works on 128 bits and leaves the destination bits above them untouched.
- The plain three-operand form works on 128 or 256 bits and clears everything above the active length.
- The predicated form works on 128, 256 or 512 bits. It adds per-lane masking, which either merges or zero-fills, a scalar broadcast of the second source when that source comes from memory, and a static rounding override.

The arithmetic follows IEEE 754 single precision with four rounding modes and full subnormal support. Five sticky exception flags collect events from the lanes that were actually written.

A strobe on `in_valid` captures one operation. The result is registered and appears on `dst` in the next cycle, with `out_valid` high. A two-state machine tracks whether the presented result is fresh.

- `ST_IDLE`: no new result. It moves to `ST_HOLD` when `in_valid` is high, and stays otherwise.
- `ST_HOLD`: the result from the previous cycle is on `dst`. It stays in `ST_HOLD` on another strobe and returns to `ST_IDLE` without one.

Top module: `masked_fsub_unit`

## Requirements
- R1: In every written lane, `dst` holds the correctly rounded single-precision value of src1 lane minus src2 lane. It is visible the cycle after the `in_valid` strobe.
- R2: The active lane count is set by the form and by `vlen_sel`:
  - legacy form (`form_sel` 00): always 4 lanes;
  - plain form (01): 4 lanes for `vlen_sel` 00, otherwise 8;
  - predicated form (1x): 4, 8 or 16 lanes for `vlen_sel` 00, 01 or 1x.
- R3: Lanes beyond the active count keep their `prev_dst` value in the legacy form and are zero in the other forms.
- R4: Masking applies only in the predicated form with `mask_on` high.
  - An active lane with its `lane_mask` bit clear is not written. It takes `prev_dst` when `zero_fill` is 0 and zero when `zero_fill` is 1.
  - In every other case all active lanes are written and `lane_mask` has no effect.
- R5: In the predicated form with `src2_is_mem` and `bcast` both high, bits 31:0 of `src2` are used as the second operand of every lane. Otherwise each lane uses its own src2 element.
- R6: `rm_static` replaces `rm_ctrl` only when all of these hold: predicated form, 16 lanes, `src2_is_mem` low and `bcast` high. Both fields use the encoding 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R7: Inexact results round according to the selected mode. An exact zero difference of opposite-signed operands is +0, except toward minus infinity, where it is -0.
- R8: On overflow the result is signed infinity, or the largest finite magnitude when the mode rounds toward zero or away from the sign. Overflow and inexact are raised.
- R9: These cases give 0x7FC00000 and raise invalid:
  - a signalling NaN operand;
  - infinity minus an infinity of the same sign.

  Otherwise a quiet NaN src1 is returned unchanged, then a quiet NaN src2 is returned unchanged, and neither raises a flag.
- R10: Subnormal operands and results are computed exactly without flushing, and a subnormal operand raises denormal. Underflow is raised only when the unrounded result is below the normal range and inexact.
- R11: `exc_sticky` bit 4 is overflow, 3 underflow, 2 invalid, 1 inexact and 0 denormal. The bits are ORed only from written lanes and stay set until reset.
- R12: An infinite operand with a finite or opposite-signed infinite partner gives the correctly signed infinity and raises no flag.
- R13: `out_valid` is high exactly in the cycle after each `in_valid` strobe. `dst` holds its value between strobes, and reset clears `dst`, `exc_sticky` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src1 | input | 512 | First source vector (minuend) |
| src2 | input | 512 | Second source vector (subtrahend) |
| prev_dst | input | 512 | Prior destination value |
| vlen_sel | input | 2 | Vector length code |
| form_sel | input | 2 | Encoding form: 00 legacy, 01 plain, 1x predicated |
| lane_mask | input | 16 | Per-lane write predicate |
| mask_on | input | 1 | Masking enable (predicated form) |
| zero_fill | input | 1 | 1 zero-fills, 0 merges unwritten active lanes |
| bcast | input | 1 | Broadcast / static-rounding bit |
| src2_is_mem | input | 1 | Second source comes from memory |
| rm_static | input | 2 | Static rounding field |
| rm_ctrl | input | 2 | Control-register rounding field |
| out_valid | output | 1 | Fresh result on dst |
| dst | output | 512 | Destination vector |
| exc_sticky | output | 5 | Sticky exception flags |

## Verification
A wrong state in the output machine shows up at once: `out_valid` is wrong in the very next cycle after a strobe, or after an idle cycle. A wrong lane decode (count, mask, broadcast or upper-bit policy) corrupts whole 32-bit lanes of `dst` in the cycle after the strobe. The sweep over every form, length, mask mode and mask pattern exposes this against `prev_dst` patterns that differ lane by lane. Datapath faults in rounding, normalisation or special-value selection show up as wrong bits of single results in that same cycle. Faults in flag collection or stickiness persist on `exc_sticky` until the next reset, where they are read after tailored operations.

// File: rtl/fsub_pkg.sv
package fsub_pkg;

    localparam int ELEM_W = 32;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ostate_e;

    // bit order matters: it is the exc_sticky layout
    typedef struct packed {
        logic ovf;
        logic unf;
        logic inv;
        logic inx;
        logic den;
    } fexc_t;

    localparam logic [31:0] QNAN_DEFAULT = 32'h7FC0_0000;

endpackage

// File: rtl/fsub_ctrl.sv
module fsub_ctrl
    import fsub_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [1:0]       form_sel,
    input  logic [1:0]       vlen_sel,
    input  logic [LANES-1:0] lane_mask,
    input  logic             mask_on,
    input  logic             zero_fill,
    input  logic             bcast,
    input  logic             src2_is_mem,
    input  logic [1:0]       rm_static,
    input  logic [1:0]       rm_ctrl,
    output logic [LANES-1:0] lane_act,
    output logic [LANES-1:0] lane_wr,
    output logic             zero_off,
    output logic             keep_high,
    output logic             use_bcst,
    output logic [1:0]       rm_eff
);
    logic       pred;
    logic [1:0] eff_vl;
    logic [4:0] cnt;

    assign pred = form_sel[1];

    always_comb begin
        unique case (form_sel)
            2'b00:   eff_vl = 2'd0;
            2'b01:   eff_vl = (vlen_sel == 2'b00) ? 2'd0 : 2'd1;
            default: eff_vl = vlen_sel[1] ? 2'd2 : {1'b0, vlen_sel[0]};
        endcase
        unique case (eff_vl)
            2'd0:    cnt = 5'd4;
            2'd1:    cnt = 5'd8;
            default: cnt = 5'd16;
        endcase
    end

    assign keep_high = (form_sel == 2'b00);
    assign zero_off  = pred & mask_on & zero_fill;
    assign use_bcst  = pred & src2_is_mem & bcast;
    assign rm_eff    = (pred && eff_vl == 2'd2 && !src2_is_mem && bcast) ? rm_static : rm_ctrl;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_act[j] = (5'(j) < cnt);
        assign lane_wr[j]  = lane_act[j] & (~(pred & mask_on) | lane_mask[j]);
    end

endmodule

// File: rtl/fsub_lane.sv
module fsub_lane
    import fsub_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [1:0]  rm,
    output logic [31:0] res,
    output fexc_t       exc
);
    function automatic logic [4:0] lzc27(input logic [26:0] v);
        logic [4:0] n;
        n = 5'd27;
        for (int i = 0; i < 27; i++) if (v[i]) n = 5'(26 - i);
        return n;
    endfunction

    rmode_e       rmd;
    logic         sa, sb;
    logic [7:0]   xa, xb;
    logic [22:0]  fa, fb;
    logic         a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_den, b_den;
    logic [9:0]   ea, eb, ex, ey, diff_e, lim, sh2, e_n, e_f;
    logic [23:0]  ma, mb, mx, my;
    logic         sx, sy, a_big, rs, up, inx, to_inf;
    logic [5:0]   sh;
    logic [50:0]  wide;
    logic [26:0]  my_al, mx_ext, m;
    logic [27:0]  v;
    logic [4:0]   lz;
    logic [24:0]  mr;
    logic [22:0]  frac;

    assign rmd = rmode_e'(rm);
    assign {sa, xa, fa} = op_a;
    assign sb = ~op_b[31];
    assign xb = op_b[30:23];
    assign fb = op_b[22:0];

    assign a_nan  = (&xa) & (|fa);
    assign b_nan  = (&xb) & (|fb);
    assign a_snan = a_nan & ~fa[22];
    assign b_snan = b_nan & ~fb[22];
    assign a_inf  = (&xa) & ~(|fa);
    assign b_inf  = (&xb) & ~(|fb);
    assign a_den  = (xa == 8'd0) & (|fa);
    assign b_den  = (xb == 8'd0) & (|fb);

    always_comb begin
        // unpack and order by magnitude
        ea = {2'b00, (xa == 8'd0) ? 8'd1 : xa};
        eb = {2'b00, (xb == 8'd0) ? 8'd1 : xb};
        ma = {xa != 8'd0, fa};
        mb = {xb != 8'd0, fb};
        a_big = {ea, ma} >= {eb, mb};
        sx = a_big ? sa : sb;
        sy = a_big ? sb : sa;
        ex = a_big ? ea : eb;
        ey = a_big ? eb : ea;
        mx = a_big ? ma : mb;
        my = a_big ? mb : ma;
        // align the smaller operand, folding lost bits into a sticky bit
        diff_e = ex - ey;
        sh     = (diff_e > 10'd31) ? 6'd31 : diff_e[5:0];
        wide   = {my, 27'd0} >> sh;
        my_al  = {wide[50:25], |wide[24:0]};
        mx_ext = {mx, 3'b000};
        v = (sx == sy) ? ({1'b0, mx_ext} + {1'b0, my_al})
                       : ({1'b0, mx_ext} - {1'b0, my_al});
        // normalise, stopping at the subnormal boundary
        lz  = lzc27(v[26:0]);
        lim = ex - 10'd1;
        sh2 = 10'd0;
        if (v[27]) begin
            m   = {v[27:2], |v[1:0]};
            e_n = ex + 10'd1;
        end else begin
            sh2 = ({5'd0, lz} < lim) ? {5'd0, lz} : lim;
            m   = v[26:0] << sh2;
            e_n = ex - sh2;
        end
        // round
        rs = (v == 28'd0 && sx != sy) ? (rmd == RM_DOWN) : sx;
        inx = |m[2:0];
        unique case (rmd)
            RM_NEAR: up = m[2] & ((|m[1:0]) | m[3]);
            RM_DOWN: up = inx & rs;
            RM_UP:   up = inx & ~rs;
            default: up = 1'b0;
        endcase
        mr = {1'b0, m[26:3]} + {24'd0, up};
        if (mr[24]) begin
            e_f  = e_n + 10'd1;
            frac = 23'd0;
        end else begin
            e_f  = mr[23] ? e_n : 10'd0;
            frac = mr[22:0];
        end
        to_inf = (rmd == RM_NEAR) | ((rmd == RM_UP) & ~rs) | ((rmd == RM_DOWN) & rs);

        exc     = '0;
        exc.den = a_den | b_den;
        if (a_nan || b_nan) begin
            if (a_snan || b_snan) begin
                res     = QNAN_DEFAULT;
                exc.inv = 1'b1;
            end else begin
                res = a_nan ? op_a : op_b;
            end
        end else if (a_inf || b_inf) begin
            if (a_inf && b_inf && sa != sb) begin
                res     = QNAN_DEFAULT;
                exc.inv = 1'b1;
            end else begin
                res = {a_inf ? sa : sb, 8'hFF, 23'd0};
            end
        end else if (e_f >= 10'd255) begin
            exc.ovf = 1'b1;
            exc.inx = 1'b1;
            res     = to_inf ? {rs, 8'hFF, 23'd0} : {rs, 8'hFE, 23'h7FFFFF};
        end else begin
            exc.inx = inx;
            exc.unf = inx & ~m[26];
            res     = {rs, e_f[7:0], frac};
        end
    end

    // R9: a NaN result needs a NaN operand or an invalid operation
    always_comb begin
        if (!a_nan && !b_nan && !exc.inv)
            nan_free_chk: assert (!((&res[30:23]) && (|res[22:0])));
    end

endmodule

// File: rtl/masked_fsub_unit.sv
module masked_fsub_unit
    import fsub_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*ELEM_W-1:0]   src1,
    input  logic [LANES*ELEM_W-1:0]   src2,
    input  logic [LANES*ELEM_W-1:0]   prev_dst,
    input  logic [1:0]                vlen_sel,
    input  logic [1:0]                form_sel,
    input  logic [LANES-1:0]          lane_mask,
    input  logic                      mask_on,
    input  logic                      zero_fill,
    input  logic                      bcast,
    input  logic                      src2_is_mem,
    input  logic [1:0]                rm_static,
    input  logic [1:0]                rm_ctrl,
    output logic                      out_valid,
    output logic [LANES*ELEM_W-1:0]   dst,
    output logic [4:0]                exc_sticky
);
    localparam int VW = LANES * ELEM_W;

    logic [LANES-1:0]      lane_act, lane_wr;
    logic                  zero_off, keep_high, use_bcst;
    logic [1:0]            rm_eff;
    logic [VW-1:0]         wb_vec;
    logic [LANES-1:0][4:0] lane_exc;
    logic [4:0]            op_flags;
    ostate_e               state, nxt;

    fsub_ctrl #(.LANES(LANES)) u_ctrl (
        .form_sel   (form_sel),
        .vlen_sel   (vlen_sel),
        .lane_mask  (lane_mask),
        .mask_on    (mask_on),
        .zero_fill  (zero_fill),
        .bcast      (bcast),
        .src2_is_mem(src2_is_mem),
        .rm_static  (rm_static),
        .rm_ctrl    (rm_ctrl),
        .lane_act   (lane_act),
        .lane_wr    (lane_wr),
        .zero_off   (zero_off),
        .keep_high  (keep_high),
        .use_bcst   (use_bcst),
        .rm_eff     (rm_eff)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [ELEM_W-1:0] b_in, r, old;
        fexc_t             e;
        assign b_in = use_bcst ? src2[ELEM_W-1:0] : src2[j*ELEM_W +: ELEM_W];
        assign old  = prev_dst[j*ELEM_W +: ELEM_W];
        fsub_lane u_lane (
            .op_a(src1[j*ELEM_W +: ELEM_W]),
            .op_b(b_in),
            .rm  (rm_eff),
            .res (r),
            .exc (e)
        );
        always_comb begin
            if (lane_wr[j])       wb_vec[j*ELEM_W +: ELEM_W] = r;
            else if (lane_act[j]) wb_vec[j*ELEM_W +: ELEM_W] = zero_off ? '0 : old;
            else                  wb_vec[j*ELEM_W +: ELEM_W] = keep_high ? old : '0;
        end
        assign lane_exc[j] = lane_wr[j] ? e : 5'd0;
    end

    always_comb begin
        op_flags = 5'd0;
        for (int j = 0; j < LANES; j++) op_flags = op_flags | lane_exc[j];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: nxt = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: nxt = in_valid ? ST_HOLD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    assign out_valid = (state == ST_HOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst        <= '0;
            exc_sticky <= 5'd0;
        end else if (in_valid) begin
            dst        <= wb_vec;
            exc_sticky <= exc_sticky | op_flags;
        end
    end

    // R13
    strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R13
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(dst));
    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_sticky & $past(exc_sticky)) == $past(exc_sticky));
    // R4
    zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form_sel[1] && mask_on && zero_fill && !lane_mask[0]
        |=> dst[ELEM_W-1:0] == '0);
    // R4
    merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form_sel[1] && mask_on && !zero_fill && !lane_mask[0]
        |=> dst[ELEM_W-1:0] == $past(prev_dst[ELEM_W-1:0]));

    if (LANES > 8) begin : g_upper_chk
        // R3
        legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && form_sel == 2'b00 |=> dst[VW-1:128] == $past(prev_dst[VW-1:128]));
        // R3
        plain_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && form_sel == 2'b01 |=> dst[VW-1:256] == '0);
    end

endmodule

// File: tb/masked_fsub_unit_test.sv
module masked_fsub_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src1 = '0, src2 = '0, prev_dst = '0;
    logic [1:0]   vlen_sel = 2'b00, form_sel = 2'b00;
    logic [15:0]  lane_mask = '0;
    logic         mask_on = 1'b0, zero_fill = 1'b0, bcast = 1'b0, src2_is_mem = 1'b0;
    logic [1:0]   rm_static = 2'b00, rm_ctrl = 2'b00;
    logic         out_valid;
    logic [511:0] dst;
    logic [4:0]   exc_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    masked_fsub_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src1(src1), .src2(src2), .prev_dst(prev_dst),
        .vlen_sel(vlen_sel), .form_sel(form_sel), .lane_mask(lane_mask),
        .mask_on(mask_on), .zero_fill(zero_fill), .bcast(bcast),
        .src2_is_mem(src2_is_mem), .rm_static(rm_static), .rm_ctrl(rm_ctrl),
        .out_valid(out_valid), .dst(dst), .exc_sticky(exc_sticky)
    );

    function automatic logic [31:0] f_of_int(int n);
        int  mag, p;
        logic s;
        if (n == 0) return 32'd0;
        s   = (n < 0);
        mag = s ? -n : n;
        p   = 0;
        for (int i = 0; i < 31; i++) if (((mag >> i) & 1) != 0) p = i;
        return {s, 8'(127 + p), 23'(mag << (23 - p))};
    endfunction

    function automatic logic [511:0] rep(logic [31:0] x);
        return {16{x}};
    endfunction

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic pulse;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one uniform op on all lanes in legacy form; checks lane 0 and flags
    task automatic uni(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] rm, input logic [31:0] er, input logic [4:0] ef);
        do_reset();
        form_sel = 2'b00; vlen_sel = 2'b00; mask_on = 1'b0; bcast = 1'b0; src2_is_mem = 1'b0;
        src1 = rep(a); src2 = rep(b); rm_ctrl = rm; rm_static = ~rm;
        pulse();
        chk({tag, " result"}, {480'd0, dst[31:0]}, {480'd0, er});
        chk({tag, " flags"}, {507'd0, exc_sticky}, {507'd0, ef});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 reset dst", dst, '0);
        chk("R13 reset flags/valid", {506'd0, out_valid, exc_sticky}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of forms, lengths, mask modes and masks (R1 R2 R3 R4 R5)
        for (int f = 0; f < 3; f++)
        for (int vl = 0; vl < 3; vl++)
        for (int me = 0; me < 2; me++)
        for (int zm = 0; zm < 2; zm++)
        for (int mi = 0; mi < 2; mi++) begin
            int s1 [16];
            int s2 [16];
            int nact, s2e;
            logic bc, mem, wr;
            logic [511:0] expv;
            bc  = (k % 3) != 1;
            mem = (k % 2) == 0;
            for (int j = 0; j < 16; j++) begin
                s1[j] = 50 + 13 * j + k;
                s2[j] = 7 * j - 20 + 3 * (k % 11);
                src1[j*32 +: 32]     = f_of_int(s1[j]);
                src2[j*32 +: 32]     = f_of_int(s2[j]);
                prev_dst[j*32 +: 32] = 32'hA500_0000 | 32'(j * 17 + k);
            end
            form_sel  = (f == 2) ? 2'b10 : 2'(f);
            vlen_sel  = (vl == 2) ? 2'b11 : 2'(vl);
            mask_on   = me[0];
            zero_fill = zm[0];
            lane_mask = mi[0] ? 16'h3C96 : 16'hA5C3;
            bcast     = bc;
            src2_is_mem = mem;
            rm_ctrl   = 2'b00;
            rm_static = 2'b11;
            nact = (f == 0) ? 4 : (f == 1) ? ((vl == 0) ? 4 : 8) : ((vl == 0) ? 4 : (vl == 1) ? 8 : 16);
            for (int j = 0; j < 16; j++) begin
                s2e = (f == 2 && mem && bc) ? s2[0] : s2[j];
                wr  = !(f == 2 && me == 1) || lane_mask[j];
                if (j < nact)
                    expv[j*32 +: 32] = wr ? f_of_int(s1[j] - s2e) : (zm == 1 ? 32'd0 : prev_dst[j*32 +: 32]);
                else
                    expv[j*32 +: 32] = (f == 0) ? prev_dst[j*32 +: 32] : 32'd0;
            end
            pulse();
            // R1 R2 R3 R4 R5
            chk($sformatf("R1/R2/R3/R4/R5 sweep f%0d vl%0d m%0d z%0d bc%0d mem%0d", f, vl, me, zm, bc, mem), dst, expv);
            chk("R13 valid after strobe", {511'd0, out_valid}, 512'd1);
            k++;
        end
        // exact integer differences raise nothing (R11)
        chk("R11 no flags after exact sweep", {507'd0, exc_sticky}, '0);
        @(negedge clk);
        chk("R13 valid drops when idle", {511'd0, out_valid}, '0);

        // rounding modes on a halfway case (R7)
        uni("R7 tie nearest", 32'h3F80_0000, 32'h3300_0000, 2'b00, 32'h3F80_0000, 5'b00010);
        uni("R7 tie zero",    32'h3F80_0000, 32'h3300_0000, 2'b11, 32'h3F7F_FFFF, 5'b00010);
        uni("R7 tie down",    32'h3F80_0000, 32'h3300_0000, 2'b01, 32'h3F7F_FFFF, 5'b00010);
        uni("R7 tie up",      32'h3F80_0000, 32'h3300_0000, 2'b10, 32'h3F80_0000, 5'b00010);
        uni("R7 neg down",    32'hBF80_0000, 32'hB300_0000, 2'b01, 32'hBF80_0000, 5'b00010);
        uni("R7 neg up",      32'hBF80_0000, 32'hB300_0000, 2'b10, 32'hBF7F_FFFF, 5'b00010);
        uni("R7 quarter nearest", 32'h3F80_0000, 32'h3340_0000, 2'b00, 32'h3F7F_FFFF, 5'b00010);
        uni("R7 zero sign nearest", 32'h4040_0000, 32'h4040_0000, 2'b00, 32'h0000_0000, 5'b00000);
        uni("R7 zero sign down",    32'h4040_0000, 32'h4040_0000, 2'b01, 32'h8000_0000, 5'b00000);
        // overflow (R8)
        uni("R8 overflow nearest", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 2'b00, 32'h7F80_0000, 5'b10010);
        uni("R8 overflow zero",    32'h7F7F_FFFF, 32'hFF7F_FFFF, 2'b11, 32'h7F7F_FFFF, 5'b10010);
        uni("R8 overflow neg up",  32'hFF7F_FFFF, 32'h7F7F_FFFF, 2'b10, 32'hFF7F_FFFF, 5'b10010);
        // NaN and invalid (R9)
        uni("R9 inf minus inf",  32'h7F80_0000, 32'h7F80_0000, 2'b00, 32'h7FC0_0000, 5'b00100);
        uni("R9 signalling nan", 32'h7F80_0001, 32'h3F80_0000, 2'b00, 32'h7FC0_0000, 5'b00100);
        uni("R9 quiet src1",     32'h7FC1_2345, 32'hFFC0_0001, 2'b00, 32'h7FC1_2345, 5'b00000);
        uni("R9 quiet src2",     32'h3F80_0000, 32'hFFC0_0001, 2'b00, 32'hFFC0_0001, 5'b00000);
        // infinities (R12)
        uni("R12 one minus inf", 32'h3F80_0000, 32'h7F80_0000, 2'b00, 32'hFF80_0000, 5'b00000);
        uni("R12 inf minus neg inf", 32'h7F80_0000, 32'hFF80_0000, 2'b00, 32'h7F80_0000, 5'b00000);
        // subnormals (R10)
        uni("R10 subnormal exact", 32'h0000_0003, 32'h0000_0001, 2'b00, 32'h0000_0002, 5'b00001);
        uni("R10 normal to subnormal", 32'h0080_0001, 32'h0000_0002, 2'b00, 32'h007F_FFFF, 5'b00001);

        // rounding source selection (R6): tie case, static toward zero, control nearest
        do_reset();
        src1 = rep(32'h3F80_0000); src2 = rep(32'h3300_0000); prev_dst = '0;
        form_sel = 2'b10; mask_on = 1'b0; rm_ctrl = 2'b00; rm_static = 2'b11;
        vlen_sel = 2'b10; bcast = 1'b1; src2_is_mem = 1'b0;
        pulse();
        chk("R6 static used at 512 register", dst, rep(32'h3F7F_FFFF));
        vlen_sel = 2'b01;
        pulse();
        chk("R6 control used at 256", dst, {256'd0, {8{32'h3F80_0000}}});
        vlen_sel = 2'b10; src2_is_mem = 1'b1;
        src2 = {{15{32'h4000_0000}}, 32'h3300_0000};
        pulse();
        chk("R5/R6 memory broadcast uses control mode", dst, rep(32'h3F80_0000));

        // flags only from written lanes (R11)
        do_reset();
        form_sel = 2'b10; vlen_sel = 2'b00; mask_on = 1'b1; zero_fill = 1'b0;
        bcast = 1'b0; src2_is_mem = 1'b0; rm_ctrl = 2'b00;
        src1 = {{12{32'h7F80_0001}}, {3{32'h3F80_0000}}, 32'h7F80_0000};
        src2 = {{12{32'h7F80_0001}}, {3{32'h3F80_0000}}, 32'h7F80_0000};
        prev_dst = rep(32'h1234_5678);
        lane_mask = 16'hFFFE;
        pulse();
        chk("R11 masked and inactive lanes raise nothing", {507'd0, exc_sticky}, '0);
        chk("R4 masked lane merges", {480'd0, dst[31:0]}, {480'd0, 32'h1234_5678});
        lane_mask = 16'hFFFF;
        pulse();
        chk("R11 written lane raises invalid", {507'd0, exc_sticky}, {507'd0, 5'b00100});
        src1 = rep(32'h3F80_0000); src2 = rep(32'h3F80_0000);
        pulse();
        chk("R11 invalid stays sticky", {507'd0, exc_sticky}, {507'd0, 5'b00100});
        @(negedge clk);
        chk("R13 dst holds between strobes", dst, {384'd0, {4{32'h0000_0000}}});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule